// File: doc/BRIEF.md
# Supervisor Watchdog and Reset Sequencer

This block drives the single reset line of a processor. It combines a supply-good flag from an external comparator with a watchdog that the processor services over its serial bus. While the supply is bad, reset is held. Once the supply recovers, reset is released only after a fixed settling delay. After release, a watchdog counts clock cycles. If the watchdog runs out before the processor services it, the block drives a reset pulse of fixed length.

The processor services the watchdog by sending a bus start condition and then, at some later point, a stop condition. A serial bus front end turns these conditions into one-cycle strobes. A 2-bit code from a control register selects the watchdog period, and one of its values switches the watchdog off. All times are given in milliseconds and are scaled by a ticks-per-millisecond parameter, so a simulation can run with short times. The active level of the reset output is fixed at build time.

The sequencer is a four-state machine:
- HOLD: reset active, supply bad.
- SETTLE: reset active, supply good, the settling delay is running.
- RUN: reset released, the watchdog is counting.
- PULSE: reset active, the watchdog reset pulse is running.

Its transitions are:
- Any state goes to HOLD when the supply is bad.
- HOLD goes to SETTLE on a good supply.
- SETTLE goes to RUN when the settling delay ends.
- RUN stays in RUN on a valid restart, which clears the count.
- RUN goes to PULSE when the watchdog expires.
- PULSE goes to RUN when the pulse ends.

Top module: `sup_rst_seq`

## Requirements
- R1: During and after the power-on reset input, reset is active. It is released exactly SETTLE_MS×TICKS_PER_MS cycles after the first clock edge that samples `supply_ok` high in HOLD, provided `supply_ok` stays high.
- R2: A clock edge that samples `supply_ok` low makes reset active from that edge onward, whatever the state.
- R3: If `supply_ok` drops during the settling delay, the delay restarts from zero once the supply is good again.
- R4: The period code selects the watchdog timeout, counted from release or from the last restart: code 00 gives WD_LONG_MS (1400 ms), code 01 gives WD_MID_MS (600 ms), and code 10 gives WD_SHORT_MS (200 ms), each multiplied by TICKS_PER_MS in cycles.
- R5: Code 11 disables the watchdog. After power-on the latched code is 11, so no timeout occurs before the first latch of a different code.
- R6: A restart happens only on an edge that samples `bus_stop` high in RUN after an earlier `bus_start` in RUN. A stop without a preceding start, or a start without a following stop, leaves the timer running.
- R7: On a watchdog timeout, reset is active for exactly PULSE_MS×TICKS_PER_MS cycles. It is then released and the watchdog counts again from zero.
- R8: `period_sel` is latched only at reset release and at a valid restart. A change made between these events does not alter the running timeout.
- R9: A start condition seen while reset is active is discarded. A stop after release therefore does not restart the timer.
- R10: With ACTIVE_LOW=1, `reset_out` is 0 when reset is active. With ACTIVE_LOW=0, it is 1 when reset is active.
- R11: `bus_hold` is high exactly while reset is active, so that the bus front end drops commands in progress and stays inhibited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Supply-good flag from the external comparator |
| bus_start | input | 1 | One-cycle strobe for a bus start condition |
| bus_stop | input | 1 | One-cycle strobe for a bus stop condition |
| period_sel | input | 2 | Watchdog period code |
| reset_out | output | 1 | Processor reset, polarity set by ACTIVE_LOW |
| bus_hold | output | 1 | High while reset is active; tells the front end to terminate and inhibit commands |

## Verification
On every cycle, the assertions check the following:
- A low supply sample forces reset and bus hold on the next cycle.
- No release happens before the supply has been good for the whole settling window.
- Every active reset interval lasts at least the shorter of the settling and pulse windows.

Several behaviours depend on event history: which start/stop pairings count as a restart, when a new period code takes effect, and the exact cycle of each timeout. Only the bench's scenarios can show these, by comparing both polarity builds against a cycle-by-cycle reference model.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        SUP_HOLD   = 2'd0,
        SUP_SETTLE = 2'd1,
        SUP_RUN    = 2'd2,
        SUP_PULSE  = 2'd3
    } sup_state_e;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_code_e;
endpackage

// File: rtl/sup_elapsed_ctr.sv
module sup_elapsed_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] count
);
    // Saturating up-counter; clr has priority.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (count != {CW{1'b1}})
            count <= count + 1'b1;
    end
endmodule

// File: rtl/sup_restart_det.sv
module sup_restart_det (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic start,
    input  logic stop,
    output logic restart
);
    logic armed_q;

    // A start arms; a later stop fires and disarms. Abort drops the arm.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (abort)
            armed_q <= 1'b0;
        else
            armed_q <= start | (armed_q & ~stop);
    end

    assign restart = armed_q & stop & ~abort;
endmodule

// File: rtl/sup_period_map.sv
module sup_period_map
    import sup_pkg::*;
#(
    parameter int TICKS_PER_MS = 25000,
    parameter int LONG_MS      = 1400,
    parameter int MID_MS       = 600,
    parameter int SHORT_MS     = 200,
    parameter int CW           = 26
) (
    input  logic [1:0]    code,
    output logic [CW-1:0] limit,
    output logic          enable
);
    localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_MS  * TICKS_PER_MS - 1);
    localparam logic [CW-1:0] MID_LIM   = CW'(MID_MS   * TICKS_PER_MS - 1);
    localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_MS * TICKS_PER_MS - 1);

    always_comb begin
        enable = 1'b1;
        limit  = LONG_LIM;
        unique case (wd_code_e'(code))
            WD_LONG:  limit = LONG_LIM;
            WD_MID:   limit = MID_LIM;
            WD_SHORT: limit = SHORT_LIM;
            WD_OFF:   enable = 1'b0;
            default:  enable = 1'b0;
        endcase
    end
endmodule

// File: rtl/sup_rst_seq.sv
module sup_rst_seq
    import sup_pkg::*;
#(
    parameter int TICKS_PER_MS = 25000,
    parameter int SETTLE_MS    = 200,
    parameter int PULSE_MS     = 200,
    parameter int WD_LONG_MS   = 1400,
    parameter int WD_MID_MS    = 600,
    parameter int WD_SHORT_MS  = 200,
    parameter bit ACTIVE_LOW   = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic [1:0] period_sel,
    output logic       reset_out,
    output logic       bus_hold
);
    localparam int MAX_MS0 = (SETTLE_MS > PULSE_MS) ? SETTLE_MS : PULSE_MS;
    localparam int MAX_MS1 = (MAX_MS0 > WD_LONG_MS) ? MAX_MS0 : WD_LONG_MS;
    localparam int MAX_MS2 = (MAX_MS1 > WD_MID_MS) ? MAX_MS1 : WD_MID_MS;
    localparam int MAX_MS  = (MAX_MS2 > WD_SHORT_MS) ? MAX_MS2 : WD_SHORT_MS;
    localparam int CW      = $clog2(MAX_MS * TICKS_PER_MS + 1);
    localparam logic [CW-1:0] SETTLE_LIM = CW'(SETTLE_MS * TICKS_PER_MS - 1);
    localparam logic [CW-1:0] PULSE_LIM  = CW'(PULSE_MS  * TICKS_PER_MS - 1);

    sup_state_e    st_q, st_nxt;
    logic [1:0]    code_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] wd_lim;
    logic          wd_en;
    logic          clr;
    logic          load_code;
    logic          restart;
    logic          rst_act;

    sup_elapsed_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .count (cnt)
    );

    sup_restart_det u_kick (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (rst_act),
        .start   (bus_start),
        .stop    (bus_stop),
        .restart (restart)
    );

    sup_period_map #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .LONG_MS      (WD_LONG_MS),
        .MID_MS       (WD_MID_MS),
        .SHORT_MS     (WD_SHORT_MS),
        .CW           (CW)
    ) u_map (
        .code   (code_q),
        .limit  (wd_lim),
        .enable (wd_en)
    );

    // Next-state logic
    always_comb begin
        st_nxt    = st_q;
        clr       = 1'b0;
        load_code = 1'b0;
        if (!supply_ok) begin
            st_nxt = SUP_HOLD;
            clr    = 1'b1;
        end else begin
            unique case (st_q)
                SUP_HOLD: begin
                    st_nxt = SUP_SETTLE;
                    clr    = 1'b1;
                end
                SUP_SETTLE: begin
                    if (cnt == SETTLE_LIM) begin
                        st_nxt    = SUP_RUN;
                        clr       = 1'b1;
                        load_code = 1'b1;
                    end
                end
                SUP_RUN: begin
                    if (restart) begin
                        clr       = 1'b1;
                        load_code = 1'b1;
                    end else if (wd_en && cnt == wd_lim) begin
                        st_nxt = SUP_PULSE;
                        clr    = 1'b1;
                    end
                end
                SUP_PULSE: begin
                    if (cnt == PULSE_LIM) begin
                        st_nxt    = SUP_RUN;
                        clr       = 1'b1;
                        load_code = 1'b1;
                    end
                end
                default: begin
                    st_nxt = SUP_HOLD;
                    clr    = 1'b1;
                end
            endcase
        end
    end

    // State and latched period code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SUP_HOLD;
            code_q <= WD_OFF;
        end else begin
            st_q <= st_nxt;
            if (load_code)
                code_q <= period_sel;
        end
    end

    // Outputs
    always_comb begin
        rst_act  = (st_q != SUP_RUN);
        bus_hold = rst_act;
    end

    generate
        if (ACTIVE_LOW) begin : g_low
            assign reset_out = ~rst_act;
        end else begin : g_high
            assign reset_out = rst_act;
        end
    endgenerate
endmodule

// File: rtl/sup_rst_seq_chk.sv
module sup_rst_seq_chk #(
    parameter int SETTLE_CYC = 400,
    parameter int PULSE_CYC  = 400,
    parameter bit ACTIVE_LOW = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic reset_out,
    input logic bus_hold
);
    localparam int MIN_CYC = (SETTLE_CYC < PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;

    logic act;
    int   good_run;
    int   act_run;

    assign act = ACTIVE_LOW ? ~reset_out : reset_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_run <= 0;
            act_run  <= 0;
        end else begin
            good_run <= supply_ok ? ((good_run < 32'h7fff_ffff) ? good_run + 1 : good_run) : 0;
            act_run  <= act ? ((act_run < 32'h7fff_ffff) ? act_run + 1 : act_run) : 0;
        end
    end

    // R2
    supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (act && bus_hold));

    // R1
    settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act) |-> good_run >= SETTLE_CYC);

    // R7
    active_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act) |-> act_run >= MIN_CYC);

    // R10
    known_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({reset_out, bus_hold}));
endmodule

bind sup_rst_seq sup_rst_seq_chk #(
    .SETTLE_CYC (SETTLE_MS * TICKS_PER_MS),
    .PULSE_CYC  (PULSE_MS * TICKS_PER_MS),
    .ACTIVE_LOW (ACTIVE_LOW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .reset_out (reset_out),
    .bus_hold  (bus_hold)
);

// File: tb/tb_sup_rst_seq.sv
module tb_sup_rst_seq;
    localparam int TICKS = 2;
    localparam int SETTLE_C = 200 * TICKS;
    localparam int PULSE_C  = 200 * TICKS;
    localparam int LONG_C   = 1400 * TICKS;
    localparam int MID_C    = 600 * TICKS;
    localparam int SHORT_C  = 200 * TICKS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic bus_start = 1'b0;
    logic bus_stop = 1'b0;
    logic [1:0] period_sel = 2'b11;
    logic rst_lo, rst_hi, hold, hold_hi;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    sup_rst_seq #(.TICKS_PER_MS(TICKS), .ACTIVE_LOW(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .bus_start(bus_start),
        .bus_stop(bus_stop), .period_sel(period_sel), .reset_out(rst_lo), .bus_hold(hold));

    sup_rst_seq #(.TICKS_PER_MS(TICKS), .ACTIVE_LOW(1'b0)) dut_hi (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .bus_start(bus_start),
        .bus_stop(bus_stop), .period_sel(period_sel), .reset_out(rst_hi), .bus_hold(hold_hi));

    // Reference model: 0 hold, 1 settle, 2 run, 3 pulse
    int m_st = 0;
    int m_cnt = 0;
    int m_code = 3;
    bit m_armed = 1'b0;

    function automatic int lim_of(int code);
        case (code)
            0: return LONG_C;
            1: return MID_C;
            2: return SHORT_C;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        int  st0;
        bit  kick;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_code = 3; m_armed = 1'b0;
        end else begin
            st0  = m_st;
            kick = (st0 == 2) && m_armed && bus_stop;
            if (!supply_ok) begin
                m_st = 0; m_cnt = 0;
            end else if (st0 == 0) begin
                m_st = 1; m_cnt = 0;
            end else if (st0 == 1) begin
                if (m_cnt == SETTLE_C - 1) begin m_st = 2; m_cnt = 0; m_code = period_sel; end
                else m_cnt++;
            end else if (st0 == 2) begin
                if (kick) begin m_cnt = 0; m_code = period_sel; end
                else if (m_code != 3 && m_cnt == lim_of(m_code) - 1) begin m_st = 3; m_cnt = 0; end
                else m_cnt++;
            end else begin
                if (m_cnt == PULSE_C - 1) begin m_st = 2; m_cnt = 0; m_code = period_sel; end
                else m_cnt++;
            end
            if (st0 != 2) m_armed = 1'b0;
            else m_armed = bus_start | (m_armed & ~bus_stop);
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        bit exp_act;
        if (rst_n && !done) begin
            exp_act = (m_st != 2);
            n_chk++;
            if (rst_lo !== ~exp_act || hold !== exp_act) begin
                n_fail++;
                $display("FAIL %s cyc %0d: low-build reset_out=%b bus_hold=%b expected %b/%b",
                         cur_req, cyc, rst_lo, hold, ~exp_act, exp_act);
            end
            n_chk++;
            // R10 active-high build
            if (rst_hi !== exp_act || hold_hi !== exp_act) begin
                n_fail++;
                $display("FAIL R10 cyc %0d: high-build reset_out=%b bus_hold=%b expected %b/%b",
                         cyc, rst_hi, hold_hi, exp_act, exp_act);
            end
        end
    end

    task automatic check_pt(input string req, input logic act, input logic exp_val);
        n_chk++;
        if (act !== exp_val) begin
            n_fail++;
            $display("FAIL %s cyc %0d: got %b expected %b", req, cyc, act, exp_val);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic send_stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
    endtask

    task automatic kick();
        send_start();
        step(3);
        send_stop();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, cyc %0d expected < 100000", cyc);
            finish_run();
        end
    end

    initial begin
        // R1 reset state
        step(3);
        check_pt("R1", rst_lo, 1'b0);
        check_pt("R11", hold, 1'b1);
        check_pt("R10", rst_hi, 1'b1);
        step(2);
        rst_n = 1'b1;
        step(5);
        cur_req = "R1";
        supply_ok = 1'b1;
        step(300);
        check_pt("R1", rst_lo, 1'b0);
        // R3 glitch during settle restarts the window
        cur_req = "R3";
        supply_ok = 1'b0;
        step(2);
        supply_ok = 1'b1;
        step(390);
        check_pt("R3", rst_lo, 1'b0);
        step(30);
        check_pt("R3", rst_lo, 1'b1);
        // R5 default code disables the watchdog
        cur_req = "R5";
        step(3000);
        check_pt("R5", rst_lo, 1'b1);
        // R8 new code not used until restart
        cur_req = "R8";
        period_sel = 2'b10;
        step(600);
        check_pt("R8", rst_lo, 1'b1);
        // R4 short period after restart
        cur_req = "R4";
        kick();
        step(SHORT_C - 20);
        check_pt("R4", rst_lo, 1'b1);
        step(30);
        check_pt("R4", rst_lo, 1'b0);
        // R7 pulse length and release
        cur_req = "R7";
        step(PULSE_C + 20);
        check_pt("R7", rst_lo, 1'b1);
        // R6 valid kicks keep it alive
        cur_req = "R6";
        for (int i = 0; i < 4; i++) begin
            kick();
            step(300);
        end
        check_pt("R6", rst_lo, 1'b1);
        kick();
        // lone stops do not restart
        for (int i = 0; i < 5; i++) begin
            step(60);
            send_stop();
        end
        step(200);
        check_pt("R6", rst_lo, 1'b0);
        step(PULSE_C + 10);
        kick();
        // lone start does not restart
        step(100);
        send_start();
        step(SHORT_C);
        check_pt("R6", rst_lo, 1'b0);
        step(PULSE_C + 10);
        // R4 middle and long codes
        cur_req = "R4";
        period_sel = 2'b01;
        kick();
        step(MID_C + 20);
        check_pt("R4", rst_lo, 1'b0);
        step(PULSE_C);
        period_sel = 2'b00;
        kick();
        step(LONG_C - 40);
        check_pt("R4", rst_lo, 1'b1);
        step(60);
        // R9 start during pulse is discarded
        cur_req = "R9";
        period_sel = 2'b10;
        step(50);
        send_start();
        step(PULSE_C);
        send_stop();
        step(SHORT_C + 20);
        check_pt("R9", rst_lo, 1'b0);
        step(PULSE_C + 10);
        // R2 supply drop while running
        cur_req = "R2";
        step(50);
        supply_ok = 1'b0;
        @(negedge clk);
        check_pt("R2", rst_lo, 1'b0);
        check_pt("R11", hold, 1'b1);
        step(3);
        supply_ok = 1'b1;
        cur_req = "R1";
        step(SETTLE_C + 20);
        check_pt("R1", rst_lo, 1'b1);
        finish_run();
    end
endmodule